// File: doc/BRIEF.md
# POST Code Capture FIFO

This block records the progress bytes that host firmware writes to the debug I/O port during boot. Each host write strobe whose address matches the configured port is put into a 16-entry FIFO. Each entry holds the data byte and, if the timer is on, a 24-bit timestamp taken from a free-running counter. The controller-side CPU pops entries through a capture read port and sees a not-empty flag. An interrupt stays high while the fill level is at or above a programmable threshold.

A single configuration write sets every control at once: timebase select, timer enable, capture enable and threshold. It also carries two self-clearing command bits, one that flushes the FIFO and one that zeroes the timestamp. Captures are accepted only while the capture-enable bit is set. A host write that finds the FIFO full is dropped and sets a sticky overrun flag.

Top module: `postcode_capture`

## Requirements
- R1: After reset the FIFO is empty, so `fifo_nempty`, `overrun`, `irq` and `cap_rdata` are all 0, and capture is disabled.
- R2: A byte is captured only when `host_wr` is high, `host_addr` equals `BASE_ADDR` (default 0x0080, exact match with no mask), and capture enable (`cfg_wdata[5]`) was last written as 1. Writes to any other address, or with capture disabled, leave the FIFO unchanged.
- R3: `cap_rdata[7:0]` is the oldest stored byte and `cap_rdata[31:8]` is its timestamp. Entries come out in the order they were written. A `cap_rd` strobe pops the entry shown in that same cycle.
- R4: While the FIFO is empty, `cap_rdata` reads 0 and `cap_rd` has no effect: a byte written afterwards is the next one read.
- R5: The FIFO holds 16 entries. A matching write while the FIFO is full is dropped and sets `overrun`, which stays set until a flush, even after the FIFO drains.
- R6: `cfg_wdata[0]` (flush) empties the FIFO and clears `overrun`. It acts only in the cycle it is written and is not stored. A host write in the same cycle as a flush is discarded.
- R7: `irq` is high while the fill level is at or above the threshold in `cfg_wdata[9:6]`. A threshold of 0 disables the interrupt, and any value above 14 acts as 14.
- R8: While timer enable (`cfg_wdata[4]`) is set, the timestamp rises by 1 every `TB_DIV << sel` clocks, where sel is `cfg_wdata[3:2]`. With the timer disabled, the stamp stored with a byte is 0.
- R9: `cfg_wdata[1]` zeroes both the timestamp and its prescaler. After that write, an entry captured k clocks later carries stamp floor((k-1)/(TB_DIV << sel)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host I/O write strobe, one cycle |
| host_addr | input | 16 | Host I/O address |
| host_data | input | 8 | Host write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Config: [0] flush, [1] stamp clear, [3:2] timebase, [4] timer enable, [5] capture enable, [9:6] threshold |
| cap_rd | input | 1 | Capture read strobe, pops one entry |
| cap_rdata | output | 32 | Oldest entry: stamp in [31:8], byte in [7:0]; 0 when empty |
| fifo_nempty | output | 1 | FIFO holds at least one entry |
| overrun | output | 1 | Sticky flag: a byte was dropped because the FIFO was full |
| irq | output | 1 | Fill level at or above threshold |

## Verification
The bench fills the FIFO to exactly 16 entries and pushes one more. A design with an off-by-one in its full test would either keep the extra byte or lose the 16th. It also checks that the overrun flag survives a full drain, which catches a flag that clears on read. Near-miss addresses and a write that lands in the same cycle as a flush expose sloppy decode and wrong priority. The threshold is walked across its edge, including the clamp at 14 and the disable value 0. Timestamps are checked against exact tick counts for two timebases, so a prescaler that is off by one clock gives a wrong stamp.

// File: rtl/pcap_pkg.sv
// Shared types for the POST code capture block.
// Assumes the configuration word layout shown in the field positions below.
package pcap_pkg;
    localparam int CFG_W        = 10;
    localparam int CFG_FLUSH    = 0;
    localparam int CFG_TSCLR    = 1;
    localparam int CFG_SEL_LO   = 2;
    localparam int CFG_TMR_EN   = 4;
    localparam int CFG_ACTIVE   = 5;
    localparam int CFG_THR_LO   = 6;
    localparam int THR_W        = 4;

    // Stored (non-command) part of the configuration word.
    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             active;
        logic             tmr_en;
        logic [1:0]       tb_sel;
    } pcap_cfg_t;
endpackage

// File: rtl/pcap_stamp.sv
// Timestamp generator: prescaler divides clk by TB_DIV << sel, and each
// prescaler wrap advances a STAMP_W-bit counter that wraps on overflow.
// Assumes clr is a one-cycle pulse; clr takes priority over counting.
module pcap_stamp #(
    parameter int TB_DIV  = 64,
    parameter int STAMP_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [1:0]         sel,
    output logic [STAMP_W-1:0] stamp
);
    localparam int PRE_W = $clog2(TB_DIV * 8) + 1;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] limit;

    // Terminal prescaler count for the selected timebase.
    always_comb limit = PRE_W'(TB_DIV << sel) - PRE_W'(1);

    // Prescaler and timestamp counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre   <= '0;
            stamp <= '0;
        end else if (en) begin
            if (pre >= limit) begin
                pre   <= '0;
                stamp <= stamp + STAMP_W'(1);
            end else begin
                pre <= pre + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/pcap_fifo.sv
// Synchronous FIFO with show-ahead read, drop-on-full and a sticky overrun
// flag. Assumes DEPTH is a power of two. A flush wins over push and pop.
module pcap_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push_req,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop_req,
    output logic [WIDTH-1:0]           rdata,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       ovf
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wp;
    logic [AW:0]      rp;
    logic             full;
    logic             push;
    logic             pop;

    // Occupancy and the qualified push/pop strobes.
    always_comb begin
        count = wp - rp;
        empty = (wp == rp);
        full  = (count == (AW+1)'(DEPTH));
        push  = push_req && !full && !flush;
        pop   = pop_req && !empty && !flush;
        rdata = empty ? '0 : mem[rp[AW-1:0]];
    end

    // Pointers and sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            ovf <= 1'b0;
        end else begin
            if (push)             wp  <= wp + (AW+1)'(1);
            if (pop)              rp  <= rp + (AW+1)'(1);
            if (push_req && full) ovf <= 1'b1;
        end
    end

    // Entry storage, one register per slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wp[AW-1:0] == AW'(i)) mem[i] <= wdata;
        end
    end
endmodule

// File: rtl/postcode_capture.sv
// POST code capture: decodes one host I/O port, stamps each accepted byte
// and queues it for the controller CPU. Assumes single-cycle strobes on
// host_wr, cfg_we and cap_rd, all synchronous to clk.
module postcode_capture
    import pcap_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0080,
    parameter int          DEPTH     = 16,
    parameter int          STAMP_W   = 24,
    parameter int          TB_DIV    = 64,
    parameter int          THR_MAX   = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [7:0]           host_data,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 cap_rd,
    output logic [STAMP_W+7:0]   cap_rdata,
    output logic                 fifo_nempty,
    output logic                 overrun,
    output logic                 irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam int ENT_W = STAMP_W + 8;

    pcap_cfg_t          cfg;
    logic               flush;
    logic               ts_clr;
    logic               accept;
    logic [STAMP_W-1:0] stamp;
    logic [ENT_W-1:0]   entry;
    logic               empty;
    logic [CNT_W-1:0]   fill;
    logic [THR_W-1:0]   thr_eff;

    // Stored configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg <= '0;
        else if (cfg_we) cfg <= cfg_wdata[CFG_W-1:CFG_SEL_LO];
    end

    // Command pulses, port decode and the entry being pushed.
    always_comb begin
        flush   = cfg_we && cfg_wdata[CFG_FLUSH];
        ts_clr  = cfg_we && cfg_wdata[CFG_TSCLR];
        accept  = host_wr && (host_addr == ADDR_W'(BASE_ADDR)) && cfg.active;
        entry   = {cfg.tmr_en ? stamp : '0, host_data};
        thr_eff = (cfg.thr > THR_W'(THR_MAX)) ? THR_W'(THR_MAX) : cfg.thr;
    end

    pcap_stamp #(.TB_DIV(TB_DIV), .STAMP_W(STAMP_W)) u_stamp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ts_clr),
        .en    (cfg.tmr_en),
        .sel   (cfg.tb_sel),
        .stamp (stamp)
    );

    pcap_fifo #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push_req (accept),
        .wdata    (entry),
        .pop_req  (cap_rd),
        .rdata    (cap_rdata),
        .empty    (empty),
        .count    (fill),
        .ovf      (overrun)
    );

    // Status and threshold interrupt.
    always_comb begin
        fifo_nempty = !empty;
        irq = (thr_eff != '0) && (fill >= CNT_W'(thr_eff));
    end
endmodule

// File: rtl/pcap_checker.sv
// Assertion checker for postcode_capture, attached by bind below.
module pcap_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             accept,
    input logic             cap_rd,
    input logic             fifo_nempty,
    input logic             overrun,
    input logic             irq,
    input logic [DW-1:0]    cap_rdata,
    input logic [CNT_W-1:0] fill
);
    a_r4_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_nempty |-> cap_rdata == '0);
    a_r4_empty_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_nempty && cap_rd && !accept) |=> !fifo_nempty);
    a_r5_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));
    a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !flush) |=> overrun);
    a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!fifo_nempty && !overrun));
    a_r7_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fifo_nempty);
endmodule

bind postcode_capture pcap_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .DW    (ENT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .accept      (accept),
    .cap_rd      (cap_rd),
    .fifo_nempty (fifo_nempty),
    .overrun     (overrun),
    .irq         (irq),
    .cap_rdata   (cap_rdata),
    .fill        (fill)
);

// File: tb/postcode_capture_tb.sv
`timescale 1ns/1ps
module postcode_capture_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_data = '0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_wdata = '0;
    logic        cap_rd = 1'b0;
    logic [31:0] cap_rdata;
    logic        fifo_nempty, overrun, irq;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    postcode_capture #(.TB_DIV(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_data(host_data), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cap_rd(cap_rd), .cap_rdata(cap_rdata), .fifo_nempty(fifo_nempty),
        .overrun(overrun), .irq(irq)
    );

    // {address, data, expected-captured}
    localparam logic [24:0] VEC [6] = '{
        {16'h0080, 8'h11, 1'b1}, {16'h0081, 8'h22, 1'b0},
        {16'h0080, 8'hA5, 1'b1}, {16'h0000, 8'h33, 1'b0},
        {16'h0180, 8'h44, 1'b0}, {16'h0080, 8'h00, 1'b1}};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwrite(input logic [15:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic cfg(input bit fl, input bit cl, input logic [1:0] sel,
                       input bit en, input bit act, input logic [3:0] thr);
        cfg_wdata = {thr, act, en, sel, cl, fl};
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pop_check(input string req, input logic [31:0] exp);
        check(req, cap_rdata, exp);
        cap_rd = 1'b1;
        @(negedge clk);
        cap_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 nempty", {31'b0, fifo_nempty}, 0);
        check("R1 overrun", {31'b0, overrun}, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 rdata", cap_rdata, 0);
        // R2 capture disabled after reset
        hwrite(16'h0080, 8'h77);
        check("R2 inactive", {31'b0, fifo_nempty}, 0);

        // R2/R3 vector table, timer off
        cfg(1, 1, 0, 0, 1, 0);
        for (int i = 0; i < 6; i++) begin
            hwrite(VEC[i][24:9], VEC[i][8:1]);
            if (VEC[i][0]) pop_check("R3 vec", {24'h0, VEC[i][8:1]});
            else check("R2 vec ignored", {31'b0, fifo_nempty}, 0);
        end

        // R4 empty read has no effect
        pop_check("R4 empty", 32'h0);
        hwrite(16'h0080, 8'h3C);
        pop_check("R4 after empty read", 32'h0000_003C);

        // R5 fill, overrun, order, sticky
        for (int i = 0; i < 16; i++) hwrite(16'h0080, 8'(i + 8'h40));
        check("R5 not overrun at 16", {31'b0, overrun}, 0);
        hwrite(16'h0080, 8'hEE);
        check("R5 overrun", {31'b0, overrun}, 1);
        for (int i = 0; i < 16; i++) pop_check("R5 order", {24'h0, 8'(i + 8'h40)});
        check("R5 drained", {31'b0, fifo_nempty}, 0);
        check("R5 sticky", {31'b0, overrun}, 1);

        // R6 flush
        hwrite(16'h0080, 8'h01);
        cfg(1, 0, 0, 0, 1, 0);
        check("R6 flush empty", {31'b0, fifo_nempty}, 0);
        check("R6 flush overrun", {31'b0, overrun}, 0);
        host_wr = 1'b1; host_addr = 16'h0080; host_data = 8'h99;
        cfg_wdata = 10'b0000_1_0_00_0_1; cfg_we = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; cfg_we = 1'b0;
        check("R6 flush beats write", {31'b0, fifo_nempty}, 0);
        hwrite(16'h0080, 8'h02);
        check("R6 not stored", {31'b0, fifo_nempty}, 1);
        pop_check("R6 next", 32'h0000_0002);

        // R7 threshold
        cfg(1, 0, 0, 0, 1, 3);
        hwrite(16'h0080, 8'h10); hwrite(16'h0080, 8'h11);
        check("R7 below", {31'b0, irq}, 0);
        hwrite(16'h0080, 8'h12);
        check("R7 at", {31'b0, irq}, 1);
        pop_check("R7 pop", 32'h0000_0010);
        check("R7 after pop", {31'b0, irq}, 0);
        cfg(1, 0, 0, 0, 1, 15);
        for (int i = 0; i < 13; i++) hwrite(16'h0080, 8'(i));
        check("R7 clamp 13", {31'b0, irq}, 0);
        hwrite(16'h0080, 8'hFF);
        check("R7 clamp 14", {31'b0, irq}, 1);
        cfg(1, 0, 0, 0, 1, 0);
        for (int i = 0; i < 16; i++) hwrite(16'h0080, 8'(i));
        check("R7 disabled", {31'b0, irq}, 0);

        // R8/R9 timestamps
        cfg(1, 1, 0, 1, 1, 0);
        idle(10);
        hwrite(16'h0080, 8'h5A);
        pop_check("R9 stamp div2", {24'd5, 8'h5A});
        cfg(1, 1, 1, 1, 1, 0);
        idle(10);
        hwrite(16'h0080, 8'h5B);
        pop_check("R8 stamp div4", {24'd2, 8'h5B});
        cfg(1, 1, 0, 0, 1, 0);
        idle(10);
        hwrite(16'h0080, 8'h5C);
        pop_check("R8 timer off", {24'd0, 8'h5C});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule